// File: doc/BRIEF.md
# Banked Register Operand Arbiter

This block sits between the operand collectors of a multi-warp shader core and a register file split into independent banks. Every cycle it receives up to `NUM_RD` source-operand read requests and one writeback carrying up to `NUM_WB` destination registers. Each access carries a register number, a warp id and a scheduler id. The block turns each access into a bank index and decides, without waiting a cycle, which accesses may use their bank. The register storage is not part of this block.

The bank index is the register number, skewed by the warp id so that the same register of neighbouring warps falls in different banks. In unified mode the skewed value wraps over all banks. In sub-core mode the banks are split into equal contiguous slices, one per scheduler, and each access wraps only inside its own scheduler's slice. Once a bank is allocated, it stays occupied for `BANK_LAT` cycles. A writeback is all-or-nothing: it goes through only when every bank it names is free, and otherwise it is refused and the writer retries. Writes beat reads on a shared bank. Reads that collide on a bank are resolved by a rotating pointer kept per bank.

Top module: `bank_operand_arbiter`

## Requirements
- R1: In unified mode (`sub_core_mode`=0) with `WARP_SIZE`=32 (the warp skew is enabled), each bank output equals (register + warp id) mod `NUM_BANKS`. The scheduler id has no effect on it.
- R2: In sub-core mode (`sub_core_mode`=1) each bank output equals ((register + warp id) mod S) + sched_id × S, where S = `NUM_BANKS`/`NUM_SCHED`. The result always lies inside the requester's own slice.
- R3: A read is granted only while its `rd_valid` bit is set. At most one read is granted per bank per cycle, and reads to different free banks are all granted in the same cycle.
- R4: `wb_accept` is 1 only when `wb_valid` is 1, every destination whose `wb_reg_valid` bit is set maps to a free bank, and no two such destinations share a bank. A destination whose `wb_reg_valid` bit is 0 takes no part in the decision.
- R5: A refused writeback allocates no bank, so a read to that bank in the next cycle is granted.
- R6: When an accepted writeback and a read target the same bank in the same cycle, the write wins and the read is not granted. Reads to other banks are unaffected.
- R7: Reads competing for one bank are granted round-robin. After reset each bank's pointer is at requester 0. The winner is the first requester at or after the pointer, and the pointer then moves to the requester after the winner.
- R8: A bank allocated in cycle t, by a read or a write, accepts no new access in cycles t+1 to t+`BANK_LAT`-1 (with the default `BANK_LAT`=2, only cycle t+1 is blocked).
- R9: After reset no bank is busy: with no requests, `rd_grant`=0 and `wb_accept`=0, and a single request is granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_core_mode | input | 1 | 0 = banks shared by all schedulers, 1 = per-scheduler bank slices |
| rd_valid | input | NUM_RD | One read request bit per requester |
| rd_reg | input | NUM_RD×REG_W | Register number of each read |
| rd_warp | input | NUM_RD×WARP_W | Warp id of each read |
| rd_sched | input | NUM_RD×SCHED_W | Scheduler id of each read |
| rd_grant | output | NUM_RD | Read granted this cycle |
| rd_bank | output | NUM_RD×BANK_W | Bank index computed for each read |
| wb_valid | input | 1 | Writeback request |
| wb_reg_valid | input | NUM_WB | Which destination slots hold a register |
| wb_reg | input | NUM_WB×REG_W | Destination register numbers |
| wb_warp | input | WARP_W | Warp id of the writeback |
| wb_sched | input | SCHED_W | Scheduler id of the writeback |
| wb_accept | output | 1 | Writeback allocated all its banks this cycle |
| wb_bank | output | NUM_WB×BANK_W | Bank index computed for each destination |

## Verification
The hardest state to reach from the ports is the per-bank rotating pointer sitting at a chosen requester while that bank's occupancy window is also open. Grants, busy cycles and pointer motion all interact there. To get there, the stimulus resets before each scenario so that every pointer starts at requester 0. It then holds all four requesters on one bank and checks the whole grant-and-gap sequence cycle by cycle. Refused writebacks are followed at once by a read to the same bank, which shows at the ports that nothing was allocated.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;

    typedef enum logic {
        MAP_UNIFIED = 1'b0,
        MAP_SUBCORE = 1'b1
    } map_mode_e;

endpackage

// File: rtl/bank_index_map.sv
module bank_index_map
    import bank_arb_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int NUM_SCHED  = 2,
    parameter int REG_W      = 8,
    parameter int WARP_W     = 6,
    parameter int SCHED_W    = 1,
    parameter int BANK_W     = 3,
    parameter int SKEW_SHIFT = 5
) (
    input  map_mode_e          mode,
    input  logic [REG_W-1:0]   reg_num,
    input  logic [WARP_W-1:0]  warp_id,
    input  logic [SCHED_W-1:0] sched_id,
    output logic [BANK_W-1:0]  bank
);
    localparam int BASE_W = ((REG_W > WARP_W) ? REG_W : WARP_W) + 1;
    localparam int unsigned SLICE = NUM_BANKS / NUM_SCHED;

    if (NUM_BANKS % NUM_SCHED != 0) begin : g_bad_split
        $error("bank count must split evenly across schedulers");
    end

    logic [BASE_W-1:0] base;

    // skew by warp id only when the warp-size shift is nonzero
    if (SKEW_SHIFT != 0) begin : g_skew
        assign base = BASE_W'(reg_num) + BASE_W'(warp_id);
    end else begin : g_noskew
        assign base = BASE_W'(reg_num);
    end

    always_comb begin
        int unsigned b32;
        int unsigned s32;
        b32 = 32'(base);
        s32 = 32'(sched_id);
        if (mode == MAP_SUBCORE) begin
            bank = BANK_W'((b32 % SLICE) + s32 * SLICE);
        end else begin
            bank = BANK_W'(b32 % NUM_BANKS);
        end
    end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] ptr,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] ptr_next
);
    always_comb begin
        logic found;
        int   idx;
        gnt      = '0;
        ptr_next = ptr;
        found    = 1'b0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(ptr) + i) % N;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                ptr_next = IDX_W'((idx + 1) % N);
            end
        end
    end

endmodule

// File: rtl/bank_operand_arbiter.sv
module bank_operand_arbiter
    import bank_arb_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int NUM_SCHED = 2,
    parameter int NUM_RD    = 4,
    parameter int NUM_WB    = 2,
    parameter int REG_W     = 8,
    parameter int WARP_W    = 6,
    parameter int WARP_SIZE = 32,
    parameter int BANK_LAT  = 2,
    parameter int SCHED_W   = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sub_core_mode,
    input  logic [NUM_RD-1:0]          rd_valid,
    input  logic [NUM_RD*REG_W-1:0]    rd_reg,
    input  logic [NUM_RD*WARP_W-1:0]   rd_warp,
    input  logic [NUM_RD*SCHED_W-1:0]  rd_sched,
    output logic [NUM_RD-1:0]          rd_grant,
    output logic [NUM_RD*BANK_W-1:0]   rd_bank,
    input  logic                       wb_valid,
    input  logic [NUM_WB-1:0]          wb_reg_valid,
    input  logic [NUM_WB*REG_W-1:0]    wb_reg,
    input  logic [WARP_W-1:0]          wb_warp,
    input  logic [SCHED_W-1:0]         wb_sched,
    output logic                       wb_accept,
    output logic [NUM_WB*BANK_W-1:0]   wb_bank
);
    localparam int SKEW_SHIFT = $clog2(WARP_SIZE);
    localparam int IDX_W      = (NUM_RD > 1) ? $clog2(NUM_RD) : 1;
    localparam int CNT_W      = $clog2(BANK_LAT + 1);
    localparam int SLICE      = NUM_BANKS / NUM_SCHED;

    typedef struct packed {
        logic [NUM_BANKS-1:0][CNT_W-1:0] busy;
        logic [NUM_BANKS-1:0][IDX_W-1:0] ptr;
    } state_t;

    state_t    st_q, st_d;
    map_mode_e mode;

    assign mode = sub_core_mode ? MAP_SUBCORE : MAP_UNIFIED;

    logic [BANK_W-1:0] rd_bank_a [NUM_RD];
    logic [BANK_W-1:0] wb_bank_a [NUM_WB];

    // ---------------- bank mapping ----------------
    for (genvar k = 0; k < NUM_RD; k++) begin : g_rd_map
        bank_index_map #(
            .NUM_BANKS(NUM_BANKS), .NUM_SCHED(NUM_SCHED), .REG_W(REG_W),
            .WARP_W(WARP_W), .SCHED_W(SCHED_W), .BANK_W(BANK_W),
            .SKEW_SHIFT(SKEW_SHIFT)
        ) u_map (
            .mode    (mode),
            .reg_num (rd_reg[k*REG_W +: REG_W]),
            .warp_id (rd_warp[k*WARP_W +: WARP_W]),
            .sched_id(rd_sched[k*SCHED_W +: SCHED_W]),
            .bank    (rd_bank_a[k])
        );
        assign rd_bank[k*BANK_W +: BANK_W] = rd_bank_a[k];

        // R2: a sub-core read never leaves its scheduler's slice
        assert_slice_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sub_core_mode && rd_valid[k]) |->
            (32'(rd_bank_a[k]) / SLICE == 32'(rd_sched[k*SCHED_W +: SCHED_W])));
    end

    for (genvar j = 0; j < NUM_WB; j++) begin : g_wb_map
        bank_index_map #(
            .NUM_BANKS(NUM_BANKS), .NUM_SCHED(NUM_SCHED), .REG_W(REG_W),
            .WARP_W(WARP_W), .SCHED_W(SCHED_W), .BANK_W(BANK_W),
            .SKEW_SHIFT(SKEW_SHIFT)
        ) u_map (
            .mode    (mode),
            .reg_num (wb_reg[j*REG_W +: REG_W]),
            .warp_id (wb_warp),
            .sched_id(wb_sched),
            .bank    (wb_bank_a[j])
        );
        assign wb_bank[j*BANK_W +: BANK_W] = wb_bank_a[j];
    end

    // ---------------- writeback: all banks or nothing ----------------
    logic                 wb_ok;
    logic [NUM_BANKS-1:0] wb_take;

    always_comb begin
        wb_ok = wb_valid;
        for (int j = 0; j < NUM_WB; j++) begin
            if (wb_reg_valid[j]) begin
                if (st_q.busy[wb_bank_a[j]] != '0) wb_ok = 1'b0;
                for (int i = 0; i < j; i++) begin
                    if (wb_reg_valid[i] && (wb_bank_a[i] == wb_bank_a[j])) wb_ok = 1'b0;
                end
            end
        end
        wb_take = '0;
        for (int j = 0; j < NUM_WB; j++) begin
            if (wb_ok && wb_reg_valid[j]) wb_take[wb_bank_a[j]] = 1'b1;
        end
    end

    assign wb_accept = wb_ok;

    // ---------------- per-bank read arbitration ----------------
    logic [NUM_BANKS-1:0][NUM_RD-1:0] gnt_m;
    logic [NUM_BANKS-1:0][IDX_W-1:0]  ptr_nx;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NUM_RD-1:0] req;

        always_comb begin
            for (int k = 0; k < NUM_RD; k++) begin
                req[k] = rd_valid[k] && (rd_bank_a[k] == BANK_W'(b)) &&
                         (st_q.busy[b] == '0) && !wb_take[b];
            end
        end

        rr_pick #(.N(NUM_RD), .IDX_W(IDX_W)) u_pick (
            .req     (req),
            .ptr     (st_q.ptr[b]),
            .gnt     (gnt_m[b]),
            .ptr_next(ptr_nx[b])
        );

        assert_one_read_per_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(gnt_m[b]) <= 1);

        assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wb_take[b] |-> (gnt_m[b] == '0));

        if (BANK_LAT > 1) begin : g_lat_chk
            assert_busy_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_m[b] != '0) |=> ((gnt_m[b] == '0) && !wb_take[b]));
            assert_busy_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
                wb_take[b] |=> (gnt_m[b] == '0));
        end
    end

    assert_grant_has_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant & ~rd_valid) == '0);

    assert_accept_has_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_accept |-> wb_valid);

    // ---------------- next state ----------------
    always_comb begin
        st_d     = st_q;
        rd_grant = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            rd_grant = rd_grant | gnt_m[b];
            if (wb_take[b] || (gnt_m[b] != '0)) begin
                st_d.busy[b] = CNT_W'(BANK_LAT - 1);
            end else if (st_q.busy[b] != '0) begin
                st_d.busy[b] = st_q.busy[b] - CNT_W'(1);
            end
            if (gnt_m[b] != '0) st_d.ptr[b] = ptr_nx[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: tb/bank_operand_arbiter_tb.sv
module bank_operand_arbiter_tb;
    localparam int NR = 4;
    localparam int NW = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sub_core_mode;
    logic [3:0]  rd_valid;
    logic [31:0] rd_reg;
    logic [23:0] rd_warp;
    logic [3:0]  rd_sched;
    logic [3:0]  rd_grant;
    logic [11:0] rd_bank;
    logic        wb_valid;
    logic [1:0]  wb_reg_valid;
    logic [15:0] wb_reg;
    logic [5:0]  wb_warp;
    logic [0:0]  wb_sched;
    logic        wb_accept;
    logic [5:0]  wb_bank;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bank_operand_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .sub_core_mode(sub_core_mode),
        .rd_valid(rd_valid), .rd_reg(rd_reg), .rd_warp(rd_warp), .rd_sched(rd_sched),
        .rd_grant(rd_grant), .rd_bank(rd_bank),
        .wb_valid(wb_valid), .wb_reg_valid(wb_reg_valid), .wb_reg(wb_reg),
        .wb_warp(wb_warp), .wb_sched(wb_sched), .wb_accept(wb_accept), .wb_bank(wb_bank)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        rd_valid = '0; rd_reg = '0; rd_warp = '0; rd_sched = '0;
        wb_valid = 1'b0; wb_reg_valid = '0; wb_reg = '0; wb_warp = '0; wb_sched = '0;
    endtask

    task automatic set_rd(input int k, input int r, input int w, input int s);
        rd_valid[k]        = 1'b1;
        rd_reg[k*8 +: 8]   = 8'(r);
        rd_warp[k*6 +: 6]  = 6'(w);
        rd_sched[k]        = 1'(s);
    endtask

    task automatic set_wb(input logic [1:0] vmask, input int r0, input int r1, input int w, input int s);
        wb_valid         = 1'b1;
        wb_reg_valid     = vmask;
        wb_reg[7:0]      = 8'(r0);
        wb_reg[15:8]     = 8'(r1);
        wb_warp          = 6'(w);
        wb_sched         = 1'(s);
    endtask

    // advance one cycle: state updates at posedge, new inputs at negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        sub_core_mode = mode;
        clear_in();
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        #2;
        chk("R9 idle grant", 32'(rd_grant), 0);
        chk("R9 idle accept", 32'(wb_accept), 0);
        set_rd(0, 0, 0, 0);
        #2;
        chk("R9 first read granted", 32'(rd_grant), 32'h1);
    endtask

    task automatic t_unified();
        do_reset(1'b0);
        set_rd(0, 5, 7, 1);     // 12 mod 8 = 4
        set_rd(1, 255, 63, 0);  // 318 mod 8 = 6
        set_rd(2, 3, 0, 1);     // 3
        set_rd(3, 16, 1, 1);    // 17 mod 8 = 1
        #2;
        chk("R1 bank req0", 32'(rd_bank[2:0]), 4);
        chk("R1 bank req1", 32'(rd_bank[5:3]), 6);
        chk("R1 bank req2", 32'(rd_bank[8:6]), 3);
        chk("R1 bank req3", 32'(rd_bank[11:9]), 1);
        chk("R3 distinct banks all granted", 32'(rd_grant), 32'hF);
    endtask

    task automatic t_subcore();
        do_reset(1'b1);
        set_rd(0, 5, 7, 0);     // 12 mod 4 = 0 -> 0
        set_rd(1, 5, 7, 1);     // 0 + 4 = 4
        set_rd(2, 6, 1, 1);     // 7 mod 4 = 3 -> 7
        set_rd(3, 9, 0, 0);     // 1
        set_wb(2'b11, 2, 7, 0, 1); // 2 -> 6 ; 7 -> 3+4=7? no: (7+0) mod 4 = 3 -> 7
        wb_reg[15:8] = 8'd5;       // (5+0) mod 4 = 1 -> 5
        #2;
        chk("R2 bank req0", 32'(rd_bank[2:0]), 0);
        chk("R2 bank req1", 32'(rd_bank[5:3]), 4);
        chk("R2 bank req2", 32'(rd_bank[8:6]), 7);
        chk("R2 bank req3", 32'(rd_bank[11:9]), 1);
        chk("R2 wb bank0", 32'(wb_bank[2:0]), 6);
        chk("R2 wb bank1", 32'(wb_bank[5:3]), 5);
        chk("R4 sub-core wb accepted", 32'(wb_accept), 1);
        chk("R3 sub-core reads granted", 32'(rd_grant), 32'hF);
    endtask

    task automatic t_conflict();
        do_reset(1'b0);
        set_rd(0, 2, 0, 0);     // bank 2
        set_rd(1, 5, 0, 0);     // bank 5
        set_rd(2, 10, 0, 0);    // bank 2
        rd_valid[3] = 1'b0;
        rd_reg[31:24] = 8'd2;   // invalid request aimed at bank 2
        #2;
        chk("R3 one read per bank", 32'(rd_grant), 32'h3);
    endtask

    task automatic t_round_robin();
        logic [3:0] exp_seq [9];
        exp_seq = '{4'h1, 4'h0, 4'h2, 4'h0, 4'h4, 4'h0, 4'h8, 4'h0, 4'h1};
        do_reset(1'b0);
        for (int c = 0; c < 9; c++) begin
            set_rd(0, 6, 0, 0);
            set_rd(1, 14, 0, 0);
            set_rd(2, 22, 0, 0);
            set_rd(3, 30, 0, 0);
            #2;
            chk((exp_seq[c] == 4'h0) ? "R8 bank held after read" : "R7 rotating winner",
                32'(rd_grant), 32'(exp_seq[c]));
            step();
        end
    endtask

    task automatic t_writeback();
        do_reset(1'b0);
        set_wb(2'b11, 1, 2, 0, 0);      // banks 1 and 2
        #2;
        chk("R4 wb idle banks accepted", 32'(wb_accept), 1);
        step();
        set_rd(0, 1, 0, 0);             // bank 1, written last cycle
        #2;
        chk("R8 bank held after write", 32'(rd_grant), 0);
        step();
        set_wb(2'b11, 4, 12, 0, 0);     // both destinations on bank 4
        #2;
        chk("R4 wb same-bank refused", 32'(wb_accept), 0);
        step();
        set_rd(1, 4, 0, 0);
        #2;
        chk("R5 refused wb left bank free", 32'(rd_grant), 32'h2);
        step();
        set_wb(2'b01, 4, 0, 0, 0);
        #2;
        chk("R4 wb to busy bank refused", 32'(wb_accept), 0);
        step();
        set_wb(2'b01, 4, 0, 0, 0);
        #2;
        chk("R8 bank free again", 32'(wb_accept), 1);
        step();
        set_wb(2'b01, 3, 11, 0, 0);     // slot 1 (bank 3) is not valid
        #2;
        chk("R4 invalid slot ignored", 32'(wb_accept), 1);
    endtask

    task automatic t_priority();
        do_reset(1'b0);
        set_wb(2'b01, 2, 0, 0, 0);      // bank 2
        set_rd(0, 2, 0, 0);             // bank 2
        set_rd(1, 3, 0, 0);             // bank 3
        #2;
        chk("R6 write wins accept", 32'(wb_accept), 1);
        chk("R6 write wins grant", 32'(rd_grant), 32'h2);
        step();
        set_wb(2'b11, 4, 12, 0, 0);     // refused: same bank twice
        set_rd(2, 4, 0, 0);
        #2;
        chk("R5 refused wb does not block read", 32'(rd_grant), 32'h4);
    endtask

    initial begin
        rst_n = 1'b0;
        sub_core_mode = 1'b0;
        clear_in();
        t_reset();
        t_unified();
        t_subcore();
        t_conflict();
        t_round_robin();
        t_writeback();
        t_priority();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule